// File: doc/BRIEF.md
# Up/down counter with separate increment and decrement strobes

This block is a binary counter, four bits wide by default, that takes two count strobes. A rising edge on the increment strobe adds one while the decrement strobe rests High. A rising edge on the decrement strobe subtracts one while the increment strobe rests High. A master clear and an active-low parallel load act on the count directly. Clear wins over load, and both win over counting.

All inputs are sampled by one free-running system clock. Each strobe passes through a synchronizer, and its edges are found between successive synchronized samples. Clear and load act at the next system clock edge.

Two active-low outputs, carry and borrow, are gated copies of the synchronized strobes. Carry follows the increment strobe while the count sits at its maximum. Borrow follows the decrement strobe while the count sits at zero. Because of this, the outputs of one counter can drive the strobes of the next counter to build a wider counter with no extra logic.

Top module: `updown_strobe_counter`

## Requirements
- R1: The count is unsigned binary of WIDTH bits (default 4, values 0 to 15). Counting up from the maximum gives 0, and counting down from 0 gives the maximum.
- R2: A 0-to-1 change of the synchronized increment strobe adds one to the count, provided the synchronized decrement strobe was High in both the current and the previous sample. With the default of two synchronizer stages, the count changes on the third rising clk edge after the strobe input rises.
- R3: A 0-to-1 change of the synchronized decrement strobe subtracts one from the count, under the mirror condition: the increment strobe must have been High in both samples.
- R4: A rising edge on one strobe is ignored, and the count held, while the other strobe is Low. When both strobes rise in the same sample, both edges are ignored.
- R5: While clear is High, the count becomes 0 at the next clk edge. This overrides the load and both strobes.
- R6: While load_n is Low and clear is Low, the count takes load_data at the next clk edge, whatever the strobes do.
- R7: No count edge is taken in a cycle where clear or load is active. A strobe held Low through a clear or load and released afterwards counts on its next rising edge.
- R8: carry_n is Low exactly when the count is at its maximum and the synchronized increment strobe is Low. Otherwise it is High.
- R9: borrow_n is Low exactly when the count is 0 and the synchronized decrement strobe is Low. Otherwise it is High.
- R10: Two counters chained form a counter twice as wide. In the chain, carry_n drives the next counter's up_strobe and borrow_n drives its down_strobe. The chained counter counts up and down correctly across the 15/0 boundaries of the low counter.
- R11: An asynchronous Low on rst_n sets the count to 0 and presets the synchronizers to High. After reset, carry_n and borrow_n are High, and strobes that are High do not produce a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_strobe | input | 1 | Increment strobe; counts on rising edge |
| down_strobe | input | 1 | Decrement strobe; counts on rising edge |
| clear | input | 1 | Master clear, active High, highest priority |
| load_n | input | 1 | Parallel load, active Low |
| load_data | input | WIDTH | Value taken by a load |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry: Low at maximum while increment strobe Low |
| borrow_n | output | 1 | Active-low borrow: Low at zero while decrement strobe Low |

## Verification
The bench chains two counters into an 8-bit counter and drives it with random pulses, loads and clears. It then aims directed cases at the 0x0F/0x10 and 0x00/0xFF crossings; a counter that wrapped the wrong way or missed the carry edge would give a wrong upper nibble. It raises one strobe while the other is held Low, and raises both strobes together; a design without arbitration would step the count there. It holds a strobe Low through a load and then releases it, which catches a design that masks the edge that follows. It asserts clear together with load to expose a design with the priority reversed. It checks carry_n and borrow_n while the strobe is Low at the terminal counts, which catches outputs that are plain level flags and not gated copies of the strobe.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Arbitration of one cycle: controls mask edges; an edge needs the
  // other strobe High now and one sample earlier.
  function automatic step_e decide_step(
    input logic clear,
    input logic load_n,
    input logic up_rise,
    input logic up_steady,
    input logic dn_rise,
    input logic dn_steady
  );
    if (clear || !load_n)          return STEP_NONE;
    else if (up_rise && dn_steady) return STEP_UP;
    else if (dn_rise && up_steady) return STEP_DOWN;
    else                           return STEP_NONE;
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic level_o,
  output logic rise_o,
  output logic steady_hi_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= strobe_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], strobe_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[LAST];
  end

  assign level_o     = chain_q[LAST];
  assign rise_o      = chain_q[LAST] & ~prev_q;
  assign steady_hi_o = chain_q[LAST] & prev_q;

  // A rising edge of the synchronized strobe lasts one cycle.
  assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/count_core.sv
module count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_data,
  input  step_e            step,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  function automatic logic [WIDTH-1:0] bump(input logic [WIDTH-1:0] v,
                                            input step_e s);
    case (s)
      STEP_UP:   return v + ONE;
      STEP_DOWN: return v - ONE;
      default:   return v;
    endcase
  endfunction

  always_comb begin
    if (clear)        count_d = '0;
    else if (!load_n) count_d = load_data;
    else              count_d = bump(count_q, step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count_q == '0);

  assert_load_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_n) |=> count_q == $past(load_data));

  assert_up_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && step == STEP_UP) |=> count_q == $past(count_q) + WIDTH'(1));

  assert_down_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && step == STEP_DOWN) |=> count_q == $past(count_q) - WIDTH'(1));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && step == STEP_NONE) |=> $stable(count_q));

endmodule

// File: rtl/term_detect.sv
module term_detect #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] count,
  input  logic             up_level,
  input  logic             dn_level,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = '1;

  function automatic logic gate_low(input logic at_end, input logic strobe);
    return ~(at_end & ~strobe);
  endfunction

  logic at_top;
  logic at_zero;

  assign at_top   = (count == TOP);
  assign at_zero  = (count == '0);
  assign carry_n  = gate_low(at_top, up_level);
  assign borrow_n = gate_low(at_zero, dn_level);

  assert_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (count == TOP && !up_level));

  assert_borrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (count == '0 && !dn_level));

endmodule

// File: rtl/updown_strobe_counter.sv
module updown_strobe_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_strobe,
  input  logic             down_strobe,
  input  logic             clear,
  input  logic             load_n,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int NSTROBE = 2;
  localparam int IDX_UP  = 0;
  localparam int IDX_DN  = 1;

  logic [NSTROBE-1:0] strobe_raw;
  logic [NSTROBE-1:0] strobe_lvl;
  logic [NSTROBE-1:0] strobe_rise;
  logic [NSTROBE-1:0] strobe_steady;

  assign strobe_raw[IDX_UP] = up_strobe;
  assign strobe_raw[IDX_DN] = down_strobe;

  genvar g;
  generate
    for (g = 0; g < NSTROBE; g++) begin : g_sync
      strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_in   (strobe_raw[g]),
        .level_o     (strobe_lvl[g]),
        .rise_o      (strobe_rise[g]),
        .steady_hi_o (strobe_steady[g])
      );
    end
  endgenerate

  // Named events for the checks below.
  logic  up_evt;
  logic  dn_evt;
  step_e step;

  assign step   = decide_step(clear, load_n,
                              strobe_rise[IDX_UP], strobe_steady[IDX_UP],
                              strobe_rise[IDX_DN], strobe_steady[IDX_DN]);
  assign up_evt = (step == STEP_UP);
  assign dn_evt = (step == STEP_DOWN);

  count_core #(.WIDTH(WIDTH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .load_n    (load_n),
    .load_data (load_data),
    .step      (step),
    .count     (count)
  );

  term_detect #(.WIDTH(WIDTH)) u_term (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .up_level (strobe_lvl[IDX_UP]),
    .dn_level (strobe_lvl[IDX_DN]),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({up_evt, dn_evt}) <= 1);

  assert_ignore_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise[IDX_UP] && !strobe_steady[IDX_DN] && load_n && !clear) |=> $stable(count));

  assert_ignore_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_rise[IDX_DN] && !strobe_steady[IDX_UP] && load_n && !clear) |=> $stable(count));

  assert_ctrl_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear || !load_n) |-> !(up_evt || dn_evt));

endmodule

// File: tb/test_updown_strobe_counter.sv
module test_updown_strobe_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_s = 1'b1, dn_s = 1'b1, clr = 1'b0, ld_n = 1'b1;
  logic [7:0] ld_val = '0;
  logic [W-1:0] cnt_lo, cnt_hi;
  logic c_lo, b_lo, c_hi, b_hi;

  always #2 clk = ~clk;

  updown_strobe_counter #(.WIDTH(W)) i_updown_strobe_counter (
    .clk(clk), .rst_n(rst_n), .up_strobe(up_s), .down_strobe(dn_s),
    .clear(clr), .load_n(ld_n), .load_data(ld_val[3:0]),
    .count(cnt_lo), .carry_n(c_lo), .borrow_n(b_lo));

  updown_strobe_counter #(.WIDTH(W)) i_updown_strobe_counter_hi (
    .clk(clk), .rst_n(rst_n), .up_strobe(c_lo), .down_strobe(b_lo),
    .clear(clr), .load_n(ld_n), .load_data(ld_val[7:4]),
    .count(cnt_hi), .carry_n(c_hi), .borrow_n(b_hi));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model = '0;

  function automatic logic [7:0] next_up(input logic [7:0] v);
    return (v == 8'hFF) ? 8'h00 : v + 8'd1;
  endfunction
  function automatic logic [7:0] next_dn(input logic [7:0] v);
    return (v == 8'h00) ? 8'hFF : v - 8'd1;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_val(input string req);
    chk(req, "count8", {24'd0, cnt_hi, cnt_lo}, {24'd0, model});
  endtask

  task automatic pulse_up();
    up_s = 1'b0; cyc(6); up_s = 1'b1; cyc(8);
    model = next_up(model);
  endtask

  task automatic pulse_dn();
    dn_s = 1'b0; cyc(6); dn_s = 1'b1; cyc(8);
    model = next_dn(model);
  endtask

  task automatic do_load(input logic [7:0] v);
    ld_val = v; ld_n = 1'b0; cyc(6); ld_n = 1'b1; cyc(3);
    model = v;
  endtask

  task automatic do_clear();
    clr = 1'b1; cyc(6); clr = 1'b0; cyc(3);
    model = 8'h00;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    // R11: reset state; High strobes give no count
    chk("R11", "count after reset", {24'd0, cnt_hi, cnt_lo}, 32'h0);
    chk("R11", "carry_n after reset", {31'd0, c_lo}, 32'd1);
    chk("R11", "borrow_n after reset", {31'd0, b_lo}, 32'd1);

    // R2: up count latency: counts on third edge after strobe rises
    up_s = 1'b0; cyc(6); up_s = 1'b1;
    cyc(2);
    chk("R2", "no change before third edge", {28'd0, cnt_lo}, 32'd0);
    cyc(1);
    chk("R2", "incremented at third edge", {28'd0, cnt_lo}, 32'd1);
    cyc(8); model = 8'h01;
    chk_val("R2");

    // R8 / R1 / R10: carry across 0x0F
    do_load(8'h0F);
    chk_val("R6");
    up_s = 1'b0; cyc(4);
    chk("R8", "carry_n low at max with up low", {31'd0, c_lo}, 32'd0);
    chk("R9", "borrow_n high off zero", {31'd0, b_lo}, 32'd1);
    up_s = 1'b1; cyc(8); model = next_up(model);
    chk("R1", "low nibble wraps to 0", {28'd0, cnt_lo}, 32'd0);
    chk("R10", "cascade up 0F->10", {24'd0, cnt_hi, cnt_lo}, 32'h10);
    chk("R8", "carry_n high after wrap", {31'd0, c_lo}, 32'd1);

    // R9 / R3 / R10: borrow across 0x10 -> 0x0F
    dn_s = 1'b0; cyc(4);
    chk("R9", "borrow_n low at zero with down low", {31'd0, b_lo}, 32'd0);
    dn_s = 1'b1; cyc(8); model = next_dn(model);
    chk("R3", "cascade down 10->0F", {24'd0, cnt_hi, cnt_lo}, 32'h0F);

    // R1: full 8-bit wraps
    do_load(8'hFF); pulse_up(); chk_val("R1");
    pulse_dn(); chk_val("R1");

    // R4: up edge while down Low is ignored, then down edge counts
    do_load(8'h21);
    dn_s = 1'b0; cyc(6);
    up_s = 1'b0; cyc(6); up_s = 1'b1; cyc(8);
    chk("R4", "up edge ignored while down low", {24'd0, cnt_hi, cnt_lo}, 32'h21);
    dn_s = 1'b1; cyc(8); model = 8'h20;
    chk_val("R3");

    // R4: both rise together -> no count
    do_load(8'h35);
    up_s = 1'b0; dn_s = 1'b0; cyc(6);
    up_s = 1'b1; dn_s = 1'b1; cyc(8);
    chk("R4", "simultaneous rises ignored", {24'd0, cnt_hi, cnt_lo}, 32'h35);

    // R7: strobe Low through a load, counts once released
    up_s = 1'b0; cyc(2);
    do_load(8'h05);
    chk_val("R6");
    cyc(3); up_s = 1'b1; cyc(8); model = next_up(model);
    chk("R7", "edge after load counts", {24'd0, cnt_hi, cnt_lo}, 32'h06);

    // R5: clear wins over load and strobes
    ld_val = 8'hAA; ld_n = 1'b0; clr = 1'b1;
    up_s = 1'b0; cyc(3); up_s = 1'b1; cyc(4);
    clr = 1'b0; ld_n = 1'b1; cyc(3);
    model = 8'h00;
    chk("R5", "clear overrides load", {24'd0, cnt_hi, cnt_lo}, 32'h00);

    // Random mix
    for (int i = 0; i < 160; i++) begin
      int op;
      op = int'($urandom_range(0, 11));
      if (op < 5)       begin pulse_up(); chk_val("R2"); end
      else if (op < 10) begin pulse_dn(); chk_val("R3"); end
      else if (op == 10) begin do_load(8'($urandom())); chk_val("R6"); end
      else              begin do_clear(); chk_val("R5"); end
    end

    done = 1;
    finish_run();
  end
endmodule